// File: doc/BRIEF.md
# No-Turnaround Pipelined SRAM

This block is a synchronous single-port memory that can alternate reads and writes on every clock edge with no idle bus cycle between them. A read places its result on the data-out port one enabled edge after the command is taken. Write data is supplied two enabled edges after its command. Because of this, a read's output slot and a later write's input slot never need the same cycle. A small internal array of 256 words of 36 bits, split into four 9-bit lanes, stands in for a full-density part.

Every command is sampled on a rising edge. The command comes from three chip selects, a load/advance strobe and an active-low write enable. When the strobe requests advance, the block generates the next address of a four-beat burst from the last loaded address. The burst order is linear or interleaved, chosen by a static pin. A clock-enable pin freezes the whole pipeline. Output enable gates the data-out drive asynchronously. A sleep request shuts off the outputs after two edges and restores service after a two-edge wake-up.

The data ports carry no valid/ready pair. The data-out side has no back-pressure: an enabled read's word appears at a fixed edge, and `rdata_oe` marks when it is driven. The data-in side is always ready: `wdata` and `lane_en_n` are taken on the second enabled edge after a write command, whatever else happens on that edge.

Top module: `nta_sram`

## Requirements
- R1: A new operation is loaded on an edge only when `clk_en_n`=0, `adv_ld`=0, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load with any select inactive is a deselect: it writes nothing, and `rdata_oe` stays 0 for the slot that operation would have used.
- R2: A read taken at enabled edge k drives its word on `rdata` with `rdata_oe`=1 after enabled edge k+1, and not after edge k.
- R3: A write taken at enabled edge k stores `wdata` at enabled edge k+2. A read may follow a write, and a write may follow a read, on consecutive edges with no idle edge between them.
- R4: While `clk_en_n`=1, every synchronous input is ignored. The output register, the pipeline stages and the burst position all hold, and the sequence resumes where it stopped.
- R5: With `adv_ld`=1 the previous operation (read, write or deselect) continues at the next burst address. Only the two low address bits change. In linear order (`burst_ilv`=0) they step as start+n mod 4; in interleaved order (`burst_ilv`=1) as start XOR n. After four beats the sequence wraps back to the start.
- R6: `lane_en_n[i]` is active low and controls bits [9i+8:9i]. A write with all four lane enables high leaves the memory unchanged.
- R7: `oe_n`=1 forces `rdata_oe`=0 and `rdata`=0 at once, independent of the clock. A read taken in that state is a dummy read.
- R8: A continue (`adv_ld`=1) that follows a deselect stays deselected: it performs no write and drives no data. The same holds for a continue issued straight after reset.
- R9: Once `sleep_req` has been high at two consecutive edges, `rdata_oe` is 0 and commands are ignored. Memory contents and burst state are preserved.
- R10: On the first two edges after `sleep_req` falls, reads and deselects are served. A write command on those edges is dropped, and `wake_err` is set and stays set until reset.
- R11: A read issued on the edge after a write to the same address returns that write's lane-merged data, even though the write completes on the same edge the read is serviced.
- R12: After reset, `rdata_oe`=0, `rdata`=0, `wake_err`=0 and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| addr | input | ADDR_W | Address taken on a load |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load a new operation, 1 = continue the burst |
| wr_n | input | 1 | 0 = write, 1 = read, taken on a load |
| lane_en_n | input | LANES | Per-lane write enables, active low, taken with the write data |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| wdata | input | DATA_W | Write data, taken two enabled edges after its command |
| rdata | output | DATA_W | Read data; 0 when not driven |
| rdata_oe | output | 1 | High when `rdata` is driven (stands for the output buffer) |
| wake_err | output | 1 | Sticky flag: a write was dropped during wake-up |

## Verification
A wrong operation code in either pipeline stage shows at the ports within two enabled edges. The symptom is `rdata_oe` rising in the wrong slot, or a word being stored that a later read then exposes. A burst counter that is off by one, or that uses the wrong order, puts a different word on `rdata` on the very next continue beat. Sleep-state errors show either as `rdata_oe` staying high one edge after the second sleep edge, or as a write during wake-up that changes memory. A missed forward returns the old word on the read that directly follows a write, a single edge after the commit.

// File: rtl/nta_sram_pkg.sv
`timescale 1ns/1ps
package nta_sram_pkg;

  // Operation carried through the two pipeline stages
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Power sequencing states
  typedef enum logic [1:0] {
    PW_AWAKE  = 2'd0,
    PW_ENTER  = 2'd1,
    PW_ASLEEP = 2'd2,
    PW_WAKE   = 2'd3
  } pwr_e;

endpackage

// File: rtl/nta_sleep_ctrl.sv
`timescale 1ns/1ps
module nta_sleep_ctrl
  import nta_sram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep,
  output logic ignore_cmd,
  output logic limit_cmd
);

  pwr_e st_q, st_d;

  // Runs on every edge, independent of the clock enable
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PW_AWAKE:  st_d = sleep_req ? PW_ENTER  : PW_AWAKE;
      PW_ENTER:  st_d = sleep_req ? PW_ASLEEP : PW_AWAKE;
      PW_ASLEEP: st_d = sleep_req ? PW_ASLEEP : PW_WAKE;
      PW_WAKE:   st_d = sleep_req ? PW_ENTER  : PW_AWAKE;
      default:   st_d = PW_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PW_AWAKE;
    else        st_q <= st_d;
  end

  assign asleep     = (st_q == PW_ASLEEP);
  assign ignore_cmd = (st_q == PW_ASLEEP) && sleep_req;
  // The two wake-up edges: leaving sleep, then the recovery state
  assign limit_cmd  = ((st_q == PW_ASLEEP) && !sleep_req) || (st_q == PW_WAKE);

endmodule

// File: rtl/nta_cmd_decode.sv
`timescale 1ns/1ps
module nta_cmd_decode
  import nta_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              ignore_cmd,
  input  logic              limit_cmd,
  input  logic              burst_ilv,
  input  logic              adv_ld,
  input  logic              sel_ok,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              drop_wr
);

  localparam logic [BURST_W-1:0] CNT_ONE = {{(BURST_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  op_e                last_q;

  logic [BURST_W-1:0] cnt_nx;
  logic [BURST_W-1:0] lsb_nx;
  logic [ADDR_W-1:0]  cont_addr;
  op_e                raw_op;
  logic [ADDR_W-1:0]  raw_addr;
  logic               accept;

  always_comb begin
    cnt_nx = cnt_q + CNT_ONE;
    if (burst_ilv) lsb_nx = base_q[BURST_W-1:0] ^ cnt_nx;
    else           lsb_nx = base_q[BURST_W-1:0] + cnt_nx;
    cont_addr = {base_q[ADDR_W-1:BURST_W], lsb_nx};

    if (!adv_ld) begin
      if (!sel_ok)   raw_op = OP_IDLE;
      else if (wr_n) raw_op = OP_READ;
      else           raw_op = OP_WRITE;
      raw_addr = addr;
    end else begin
      raw_op   = last_q;
      raw_addr = cont_addr;
    end

    drop_wr  = step && limit_cmd && (raw_op == OP_WRITE);
    accept   = step && !ignore_cmd && !drop_wr;
    cmd_op   = accept ? raw_op : OP_IDLE;
    cmd_addr = raw_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      last_q <= OP_IDLE;
    end else if (accept) begin
      if (!adv_ld) begin
        base_q <= addr;
        cnt_q  <= '0;
        last_q <= raw_op;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/nta_lane_mem.sv
`timescale 1ns/1ps
module nta_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_we[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/nta_sram.sv
`timescale 1ns/1ps
module nta_sram
  import nta_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic              burst_ilv,
  input  logic              oe_n,
  input  logic              sleep_req,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              wake_err
);

  logic step;
  logic sel_ok;
  logic asleep, ignore_cmd, limit_cmd;

  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic              drop_wr;

  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;

  logic              commit;
  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] merged;
  logic              fwd;

  logic [DATA_W-1:0] out_q;
  logic              out_vld;

  assign step   = !clk_en_n;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  nta_sleep_ctrl u_sleep (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .asleep     (asleep),
    .ignore_cmd (ignore_cmd),
    .limit_cmd  (limit_cmd)
  );

  nta_cmd_decode #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .ignore_cmd (ignore_cmd),
    .limit_cmd  (limit_cmd),
    .burst_ilv  (burst_ilv),
    .adv_ld     (adv_ld),
    .sel_ok     (sel_ok),
    .wr_n       (wr_n),
    .addr       (addr),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .drop_wr    (drop_wr)
  );

  // Two command stages: stage 1 reads the array, stage 2 takes the data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_addr <= '0;
    end else if (step) begin
      s1_op   <= cmd_op;
      s1_addr <= cmd_addr;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
    end
  end

  assign commit = step && (s2_op == OP_WRITE);

  nta_lane_mem #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_mem (
    .clk     (clk),
    .we      (commit),
    .wr_addr (s2_addr),
    .lane_we (~lane_en_n),
    .wr_data (wdata),
    .rd_addr (s1_addr),
    .rd_data (arr_q)
  );

  // Bypass the write that completes on the same edge the read is serviced
  assign fwd = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (fwd && !lane_en_n[g]) ?
                                        wdata[g*LANE_W +: LANE_W] :
                                        arr_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      out_vld <= 1'b0;
    end else if (step) begin
      out_vld <= (s1_op == OP_READ);
      if (s1_op == OP_READ) out_q <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_err <= 1'b0;
    else if (drop_wr) wake_err <= 1'b1;
  end

  assign rdata_oe = out_vld && !oe_n && !asleep;
  assign rdata    = rdata_oe ? out_q : '0;

endmodule

// File: rtl/nta_sram_chk.sv
`timescale 1ns/1ps
module nta_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              adv_ld,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              oe_n,
  input logic              sleep_req,
  input logic              rdata_oe,
  input logic              wake_err,
  input logic [DATA_W-1:0] out_q
);

  logic [1:0] age;
  logic       sel_on;

  assign sel_on = !sel_a_n && sel_b && !sel_c_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  // R1: deselect load then an enabled edge leaves the output undriven
  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && !sel_on) ##1 !clk_en_n |=> !rdata_oe);

  // R8: a continue after a deselect also drives nothing
  assert_cont_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && !sel_on) ##1 (!clk_en_n && adv_ld) ##1 !clk_en_n
    |=> !rdata_oe);

  // R4: the output register holds while the clock enable is off
  assert_hold_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) && clk_en_n |=> $stable(out_q));

  // R7: output enable high always silences the data output
  assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe);

  // R9: two consecutive sleep edges turn the output off
  assert_sleep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) && sleep_req && $past(sleep_req) |=> !rdata_oe);

  // R10: the wake-up error flag is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_err |=> wake_err);

endmodule

bind nta_sram nta_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en_n  (clk_en_n),
  .adv_ld    (adv_ld),
  .sel_a_n   (sel_a_n),
  .sel_b     (sel_b),
  .sel_c_n   (sel_c_n),
  .oe_n      (oe_n),
  .sleep_req (sleep_req),
  .rdata_oe  (rdata_oe),
  .wake_err  (wake_err),
  .out_q     (out_q)
);

// File: tb/nta_sram_tb.sv
`timescale 1ns/1ps
module nta_sram_tb;

  localparam int AW = 8;
  localparam int NL = 4;
  localparam int DW = 36;

  localparam logic [2:0] SEL_ON  = 3'b010;  // {sel_a_n, sel_b, sel_c_n}
  localparam logic [2:0] SEL_OFF = 3'b110;
  localparam logic [NL-1:0] ALL  = 4'b0000;
  localparam logic [NL-1:0] NONE = 4'b1111;

  localparam logic [DW-1:0] D1   = 36'h123456789;
  localparam logic [DW-1:0] DA   = 36'hABCDE0123;
  localparam logic [DW-1:0] DB   = 36'h0F0F0F0F0;
  localparam logic [DW-1:0] DOLD = 36'h000000000;
  localparam logic [DW-1:0] DNEW = 36'hFFFFFFFFF;
  localparam logic [DW-1:0] JUNK = 36'hDEADBEEF5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          clk_en_n;
  logic [AW-1:0] addr;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          adv_ld, wr_n;
  logic [NL-1:0] lane_en_n;
  logic          burst_ilv, oe_n, sleep_req;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_oe, wake_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  nta_sram u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .addr(addr),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .adv_ld(adv_ld),
    .wr_n(wr_n), .lane_en_n(lane_en_n), .burst_ilv(burst_ilv), .oe_n(oe_n),
    .sleep_req(sleep_req), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .wake_err(wake_err)
  );

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return 36'h5A0000000 | {28'h0, a};
  endfunction

  function automatic logic [DW-1:0] lane_mix(logic [DW-1:0] oldv, logic [DW-1:0] newv,
                                             logic [NL-1:0] ln);
    logic [DW-1:0] r = oldv;
    for (int i = 0; i < NL; i++) if (!ln[i]) r[i*9 +: 9] = newv[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // One edge: drive at the falling edge, step through the rising edge, return at the next falling edge
  task automatic go(logic load, logic [2:0] sel, logic wr, logic [AW-1:0] a,
                    logic [DW-1:0] wd, logic [NL-1:0] ln);
    adv_ld = ~load;
    {sel_a_n, sel_b, sel_c_n} = sel;
    wr_n = ~wr; addr = a; wdata = wd; lane_en_n = ln;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic c_rd(logic [AW-1:0] a, logic [DW-1:0] wd, logic [NL-1:0] ln);
    go(1'b1, SEL_ON, 1'b0, a, wd, ln);
  endtask
  task automatic c_wr(logic [AW-1:0] a, logic [DW-1:0] wd, logic [NL-1:0] ln);
    go(1'b1, SEL_ON, 1'b1, a, wd, ln);
  endtask
  task automatic c_nop(logic [DW-1:0] wd, logic [NL-1:0] ln);
    go(1'b1, SEL_OFF, 1'b0, '0, wd, ln);
  endtask
  task automatic c_cont(logic [DW-1:0] wd, logic [NL-1:0] ln);
    go(1'b0, SEL_ON, 1'b0, '0, wd, ln);
  endtask

  task automatic t_reset();
    chk("R12", "rdata_oe after reset", {35'h0, rdata_oe}, '0);
    chk("R12", "wake_err after reset", {35'h0, wake_err}, '0);
    chk("R12", "rdata after reset", rdata, '0);
    c_cont(JUNK, ALL);  // continue straight after reset: deselected
    c_nop(JUNK, ALL);
    chk("R8", "continue after reset drives", {35'h0, rdata_oe}, '0);
  endtask

  task automatic t_write_read();
    c_wr(8'h10, '0, NONE);
    c_nop('0, NONE);
    c_nop(D1, ALL);          // data two edges after command
    c_rd(8'h10, '0, NONE);
    chk("R2", "no data one edge early", {35'h0, rdata_oe}, '0);
    c_nop('0, NONE);
    chk("R2", "read drive", {35'h0, rdata_oe}, 36'h1);
    chk("R3", "read after late write", rdata, D1);
    c_nop('0, NONE);
  endtask

  task automatic t_alternate();
    c_wr(8'h20, '0, NONE);
    c_rd(8'h10, '0, NONE);
    c_wr(8'h21, DA, ALL);
    chk("R3", "read between writes", rdata, D1);
    c_rd(8'h20, '0, NONE);
    chk("R3", "write slot undriven", {35'h0, rdata_oe}, '0);
    c_nop(DB, ALL);
    chk("R3", "alternating read data", rdata, DA);
    c_nop('0, NONE);
    c_rd(8'h21, '0, NONE);
    c_nop('0, NONE);
    chk("R3", "second write landed", rdata, DB);
  endtask

  task automatic t_forward();
    c_wr(8'h30, '0, NONE);
    c_nop('0, NONE);
    c_nop(DOLD, ALL);
    c_wr(8'h30, '0, NONE);
    c_rd(8'h30, '0, NONE);
    c_nop(DNEW, 4'b1010);
    chk("R11", "forwarded merged word", rdata, lane_mix(DOLD, DNEW, 4'b1010));
    c_nop('0, NONE);
    c_rd(8'h30, '0, NONE);
    c_nop('0, NONE);
    chk("R6", "lane-masked word stored", rdata, lane_mix(DOLD, DNEW, 4'b1010));
  endtask

  task automatic t_abort();
    c_wr(8'h10, '0, NONE);
    c_nop('0, NONE);
    c_nop(JUNK, NONE);        // all lanes off: abort
    c_rd(8'h10, '0, NONE);
    c_nop('0, NONE);
    chk("R6", "aborted write left word", rdata, D1);
  endtask

  task automatic t_burst();
    burst_ilv = 1'b0;
    c_wr(8'h41, '0, NONE);
    c_cont('0, NONE);
    c_cont(pat(8'h41), ALL);
    c_cont(pat(8'h42), ALL);
    c_nop(pat(8'h43), ALL);
    c_nop(pat(8'h40), ALL);
    c_rd(8'h41, '0, NONE);
    c_cont('0, NONE);
    chk("R5", "linear beat 0", rdata, pat(8'h41));
    c_cont('0, NONE);
    chk("R5", "linear beat 1", rdata, pat(8'h42));
    c_cont('0, NONE);
    chk("R5", "linear beat 2", rdata, pat(8'h43));
    c_nop('0, NONE);
    chk("R5", "linear beat 3 wraps", rdata, pat(8'h40));
    c_nop('0, NONE);
    burst_ilv = 1'b1;
    c_rd(8'h41, '0, NONE);
    c_cont('0, NONE);
    chk("R5", "interleaved beat 0", rdata, pat(8'h41));
    c_cont('0, NONE);
    chk("R5", "interleaved beat 1", rdata, pat(8'h40));
    c_cont('0, NONE);
    chk("R5", "interleaved beat 2", rdata, pat(8'h43));
    c_nop('0, NONE);
    chk("R5", "interleaved beat 3", rdata, pat(8'h42));
    c_nop('0, NONE);
    burst_ilv = 1'b0;
  endtask

  task automatic t_hold();
    c_rd(8'h40, '0, NONE);
    c_cont('0, NONE);
    chk("R4", "before hold", rdata, pat(8'h40));
    clk_en_n = 1'b1;
    c_wr(8'h10, JUNK, ALL);
    chk("R4", "held edge 1", rdata, pat(8'h40));
    c_wr(8'h10, JUNK, ALL);
    chk("R4", "held edge 2", rdata, pat(8'h40));
    clk_en_n = 1'b0;
    c_cont('0, NONE);
    chk("R4", "burst resumes", rdata, pat(8'h41));
    c_nop('0, NONE);
    chk("R4", "burst continues", rdata, pat(8'h42));
    c_nop('0, NONE);
  endtask

  task automatic t_oe();
    c_rd(8'h10, '0, NONE);
    c_nop('0, NONE);
    chk("R7", "driven with oe low", rdata, D1);
    oe_n = 1'b1;
    #0.5;
    chk("R7", "oe high silences drive", {35'h0, rdata_oe}, '0);
    chk("R7", "oe high zero data", rdata, '0);
    oe_n = 1'b0;
    #0.5;
    chk("R7", "oe low restores", rdata, D1);
    c_nop('0, NONE);
  endtask

  task automatic t_desel();
    logic [2:0] pats [3] = '{3'b110, 3'b000, 3'b011};
    for (int i = 0; i < 3; i++) begin
      go(1'b1, pats[i], 1'b0, 8'h10, '0, NONE);
      c_cont(JUNK, ALL);
      chk("R1", "deselected read drives", {35'h0, rdata_oe}, '0);
      go(1'b1, pats[i], 1'b1, 8'h10, '0, NONE);
      chk("R8", "continue-deselect drives", {35'h0, rdata_oe}, '0);
      c_cont(JUNK, ALL);
      c_nop(JUNK, ALL);
      c_nop(JUNK, ALL);
    end
    c_rd(8'h10, '0, NONE);
    c_nop('0, NONE);
    chk("R1", "deselected writes had no effect", rdata, D1);
  endtask

  task automatic t_sleep();
    chk("R10", "no error before sleep", {35'h0, wake_err}, '0);
    sleep_req = 1'b1;
    c_rd(8'h10, '0, NONE);
    c_nop('0, NONE);
    chk("R9", "output off once asleep", {35'h0, rdata_oe}, '0);
    c_wr(8'h10, '0, NONE);
    c_rd(8'h10, JUNK, ALL);
    c_nop(JUNK, ALL);
    chk("R9", "read while asleep silent", {35'h0, rdata_oe}, '0);
    sleep_req = 1'b0;
    c_wr(8'h21, '0, NONE);
    chk("R10", "write in wake-up flagged", {35'h0, wake_err}, 36'h1);
    c_rd(8'h10, JUNK, ALL);
    c_nop(JUNK, ALL);
    chk("R10", "read served in wake-up", {35'h0, rdata_oe}, 36'h1);
    chk("R9", "memory kept through sleep", rdata, D1);
    c_nop(JUNK, ALL);
    c_rd(8'h21, '0, NONE);
    c_nop('0, NONE);
    chk("R10", "dropped write changed nothing", rdata, DB);
    c_nop('0, NONE);
    chk("R10", "error flag sticky", {35'h0, wake_err}, 36'h1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; oe_n = 1'b0; sleep_req = 1'b0; burst_ilv = 1'b0;
    adv_ld = 1'b0; {sel_a_n, sel_b, sel_c_n} = SEL_OFF; wr_n = 1'b1;
    addr = '0; wdata = '0; lane_en_n = NONE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_alternate();
    t_forward();
    t_abort();
    t_burst();
    t_hold();
    t_oe();
    t_desel();
    t_sleep();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule